// File: doc/BRIEF.md
# Cascadable Pixel Readout Shift Register

This block is a digital model of the scanning register inside a linear image sensor die. The start input is sampled on each falling clock edge. When it is high, a token enters the first pixel position. Each later falling edge moves every token one position along. While a token sits at a position, the matching line of a one-hot select bus is high, and that line closes one pixel switch. One pixel is therefore addressed per clock period, so the pixel rate equals the clock rate.

The end-of-scan signal of a die is high while its final position holds a token. It drives the start input of the next die. The next die samples it on the same falling edge that moves the token out of the final position, so the line continues with no gap between dies. The top module chains a parameterised number of identical dies and exposes the following on its ports:

- the select bus of the whole line;
- the end-of-scan of the last die;
- a flag that is high whenever more than one token is inside the line. This shows that start was held high across several falling edges.

Top module: `cis_scan_chain`

## Requirements
- R1: While rstN is low, every select line, eosOut and multiToken are low, and this state appears without waiting for a clock edge.
- R2: A high startIn at a falling edge of clk places a token at position 1 of die 0. A low startIn at that edge enters no token, so a register that is already empty stays all zeros.
- R3: Each falling edge moves every token one position towards the end of the line. A token entered at edge e drives select bit i during the period that follows edge e+i.
- R4: eosOut is high exactly while the last bit of the bus (index NumDies*Positions-1) is high. After the token leaves that position, the bit is low unless another token follows directly behind it.
- R5: Position p of die d (p counted from 1, d from 0) maps to pixelSel[d*Positions+p-1]. After position Positions of die d, the token appears at position 1 of die d+1 in the very next period.
- R6: If startIn is high across m falling edges, m tokens enter in that order, each one position behind the one before. multiToken is high in every period in which two or more select bits are high.
- R7: When the line holds one token or none, the select bus is one-hot or all zeros, and multiToken is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; tokens are sampled and moved on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start token input to die 0 |
| pixelSel | output | NumDies*Positions | One-hot pixel select bus of the whole line |
| eosOut | output | 1 | End-of-scan of the last die |
| multiToken | output | 1 | High while two or more tokens are inside the line |

## Verification
The bench builds the line with Positions=4 and NumDies=3. That gives 12 positions, so every position, both die-to-die handoffs and the final end-of-scan are reached within one short scan. With this size the bench can drive every nonzero four-edge start pattern, 15 of them. These cover a single token, adjacent tokens, tokens with gaps, and a start held for four edges. The expected bus for each pattern is computed from the position index and the edge count. Further runs check an idle line and a reset applied in the middle of a scan.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes from the control to the shift datapath
  typedef struct packed {
    logic inject;   // value entered into position 1 at this falling edge
    logic advance;  // register moves at this falling edge
  } scanStrobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int Positions = 128,
  localparam int CntW = $clog2(Positions + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [Positions-1:0] stages,
  output scanStrobe_t          strobe,
  output logic [CntW-1:0]      tokenCount
);

  always_comb begin
    strobe.inject  = startIn;
    // Hold the register when nothing is inside and nothing arrives
    strobe.advance = startIn | (|stages);
  end

  always_comb begin
    tokenCount = '0;
    for (int i = 0; i < Positions; i++)
      tokenCount = tokenCount + CntW'(stages[i]);
  end

  // R6: a token entered behind a token still inside gives two or more
  a_r6_second_token: assert property (@(negedge clk) disable iff (!rstN)
    (strobe.inject && (|stages[Positions-2:0])) |=> (tokenCount >= CntW'(2)));

  // R3: with no token entering and none leaving, the count is kept
  a_r3_count_kept: assert property (@(negedge clk) disable iff (!rstN)
    (!strobe.inject && !stages[Positions-1]) |=> $stable(tokenCount));

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int Positions = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scanStrobe_t          strobe,
  output logic [Positions-1:0] stages,
  output logic                 eos
);

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN)
      stages <= '0;
    else if (strobe.advance)
      stages <= {stages[Positions-2:0], strobe.inject};
  end

  assign eos = stages[Positions-1];

  // R2: a captured start shows at position 1 after the edge
  a_r2_capture: assert property (@(negedge clk) disable iff (!rstN)
    strobe.inject |=> stages[0]);

  // R2: no start at an empty register keeps it empty
  a_r2_idle_kept: assert property (@(negedge clk) disable iff (!rstN)
    (!strobe.inject && stages == '0) |=> stages == '0);

  // R1: reset holds all stages clear
  a_r1_reset_clear: assert property (@(negedge clk)
    !rstN |-> stages == '0);

endmodule

// File: rtl/scan_die.sv
module scan_die
  import scan_pkg::*;
#(
  parameter int Positions = 128,
  localparam int CntW = $clog2(Positions + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  output logic [Positions-1:0] sel,
  output logic                 eos,
  output logic [CntW-1:0]      tokenCount
);

  scanStrobe_t strobe;

  scan_ctrl #(.Positions(Positions)) ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stages(sel),
    .strobe(strobe), .tokenCount(tokenCount)
  );

  scan_datapath #(.Positions(Positions)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stages(sel), .eos(eos)
  );

endmodule

// File: rtl/cis_scan_chain.sv
module cis_scan_chain #(
  parameter int Positions = 128,
  parameter int NumDies   = 2,
  localparam int LineLen  = Positions * NumDies,
  localparam int CntW     = $clog2(Positions + 1),
  localparam int TotW     = $clog2(LineLen + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startIn,
  output logic [LineLen-1:0] pixelSel,
  output logic               eosOut,
  output logic               multiToken
);

  logic [NumDies-1:0] eosChain;
  logic [CntW-1:0]    dieCount [NumDies];
  logic [TotW-1:0]    lineCount;

  for (genvar d = 0; d < NumDies; d++) begin : g_die
    logic dieStart;
    if (d == 0) begin : g_head
      assign dieStart = startIn;
    end else begin : g_link
      assign dieStart = eosChain[d-1];

      // R5: handoff into the next die with no gap
      a_r5_handoff: assert property (@(negedge clk) disable iff (!rstN)
        eosChain[d-1] |=> pixelSel[d*Positions]);
    end

    scan_die #(.Positions(Positions)) die (
      .clk(clk), .rstN(rstN), .startIn(dieStart),
      .sel(pixelSel[d*Positions +: Positions]),
      .eos(eosChain[d]), .tokenCount(dieCount[d])
    );
  end

  always_comb begin
    lineCount = '0;
    for (int d = 0; d < NumDies; d++)
      lineCount = lineCount + TotW'(dieCount[d]);
  end

  assign multiToken = (lineCount > TotW'(1));
  assign eosOut     = eosChain[NumDies-1];

  // R4: last position reached one edge after the one before it
  a_r4_eos_follows: assert property (@(negedge clk) disable iff (!rstN)
    pixelSel[LineLen-2] |=> eosOut);

  // R4: end-of-scan drops once the token leaves, when none follows
  a_r4_eos_drops: assert property (@(negedge clk) disable iff (!rstN)
    (eosOut && !pixelSel[LineLen-2]) |=> !eosOut);

  // R7: without the flag the bus is one-hot or empty
  a_r7_onehot: assert property (@(negedge clk) disable iff (!rstN)
    !multiToken |-> $onehot0(pixelSel));

endmodule

// File: tb/cis_scan_chain_test.sv
module cis_scan_chain_test;
  localparam int P = 4;
  localparam int D = 3;
  localparam int L = P * D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [L-1:0] pixelSel;
  logic eosOut, multiToken;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cis_scan_chain #(.Positions(P), .NumDies(D)) uut (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .pixelSel(pixelSel), .eosOut(eosOut), .multiToken(multiToken)
  );

  task automatic check(input string tag, input logic [L-1:0] act,
                       input logic [L-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  // Sum of token entries: position i holds a token after edge s
  // if a start was high at edge s-i.
  function automatic logic [L-1:0] expBus(input logic [3:0] pat, input int s);
    logic [L-1:0] v = '0;
    for (int i = 0; i < L; i++)
      if (s - i >= 0 && s - i < 4) v[i] = pat[s - i];
    return v;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [L-1:0] e;
    // R1: reset state
    #1;
    check("R1 sel in reset", pixelSel, '0);
    check("R1 eos in reset", {{(L-1){1'b0}}, eosOut}, '0);
    check("R1 multi in reset", {{(L-1){1'b0}}, multiToken}, '0);
    step();
    rstN = 1'b1;
    step();

    // R2, R7: idle line stays empty
    for (int k = 0; k < 5; k++) begin
      step();
      check("R2 idle sel", pixelSel, '0);
      check("R7 idle multi", {{(L-1){1'b0}}, multiToken}, '0);
    end

    // R3, R4, R5, R6, R7: every nonzero four-edge start pattern
    for (int pat = 1; pat < 16; pat++) begin
      for (int s = 0; s < L + 4; s++) begin
        startIn = (s < 4) ? pat[s] : 1'b0;
        step();
        e = expBus(pat[3:0], s);
        if ($countones(pat) == 1)
          check("R5 R3 single token sel", pixelSel, e);
        else
          check("R6 R3 token train sel", pixelSel, e);
        check("R4 eos", {{(L-1){1'b0}}, eosOut}, {{(L-1){1'b0}}, e[L-1]});
        if ($countones(e) > 1)
          check("R6 multi flag", {{(L-1){1'b0}}, multiToken}, 1);
        else
          check("R7 multi low", {{(L-1){1'b0}}, multiToken}, 0);
      end
    end

    // R1: reset in the middle of a scan clears at once
    startIn = 1'b1;
    step();
    startIn = 1'b0;
    for (int k = 0; k < 5; k++) step();
    check("R5 mid-scan position", pixelSel, L'(1) << 5);
    rstN = 1'b0;
    #1;
    check("R1 async clear sel", pixelSel, '0);
    check("R1 async clear multi", {{(L-1){1'b0}}, multiToken}, '0);
    step();
    rstN = 1'b1;
    step();
    check("R2 empty after reset", pixelSel, '0);

    finished = 1;
    summary();
  end
endmodule